// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block holds the dynamic branch prediction state used early in instruction fetch. Each clock cycle it can accept a fetch address on its lookup port. One cycle later it reports whether a recorded branch matches that address. When one does, it also reports whether the branch is predicted taken and the target to fetch from next. Each stored entry carries a tag, a target address and a 2-bit saturating direction counter. The storage is direct-mapped, and a slot is chosen by the low address bits just above the instruction alignment.

When a branch resolves, the update port reports the branch address, the actual direction, the actual target, whether the branch is unconditional, and whether it was mispredicted. The storage then changes as follows:

- A branch that misses and resolves taken, or any unconditional branch that misses, claims its slot and starts at strongly taken.
- A conditional branch that misses and resolves not taken leaves the storage untouched.
- A branch that hits moves its counter one step toward the outcome.

A miss always predicts not taken. The block has no input for static direction hints, so a prediction depends only on the stored state.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is empty: each lookup reports pr_hit=0 and pr_taken=0 until an entry has been allocated.
- R2: A lookup that misses reports pr_taken=0 and pr_target=0.
- R3: An update for a conditional branch (up_uncond=0) that misses and resolves not taken (up_taken=0) changes no entry, so later lookups of that address still miss.
- R4: An update that misses with up_taken=1 allocates the slot: the counter is set to 2'b11 (strongly taken) and up_target is stored, so the next lookup hits and predicts taken to that target.
- R5: An unconditional branch (up_uncond=1) is treated as taken whatever up_taken says, so it is allocated on its first update.
- R6: Counter encoding is 00 strongly not taken, 01 weakly not taken, 10 weakly taken, 11 strongly taken. On a hit, pr_taken is bit 1 of the stored counter and pr_target is the stored target.
- R7: An update that hits moves the counter one step toward the effective outcome, saturating at 00 and 11.
- R8: A taken update that hits replaces the stored target with up_target. A not-taken update that hits keeps the old target.
- R9: The slot index is address bits [ALIGN_BITS+IDX_W-1:ALIGN_BITS] and the tag is the bits above it. An allocation overwrites any other branch that occupies the slot, and that branch then misses.
- R10: A lookup and an update in the same cycle see the contents held before the update. The update is visible from the next lookup on.
- R11: The results of a lookup presented at clock edge k appear after edge k with pr_valid=1. In a cycle without a lookup, pr_valid, pr_hit and pr_taken are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Fetch address to look up |
| pr_valid | output | 1 | Prediction result valid |
| pr_hit | output | 1 | Lookup matched a stored branch |
| pr_taken | output | 1 | Predicted taken |
| pr_target | output | ADDR_W | Predicted target (0 on a miss) |
| up_valid | input | 1 | Branch resolution update this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction was taken |
| up_uncond | input | 1 | Branch is unconditional |
| up_mispredict | input | 1 | Branch was mispredicted |
| up_target | input | ADDR_W | Actual branch target |

## Verification
The assertions assume that both lookup and update addresses are aligned, meaning their low ALIGN_BITS bits are zero. They also assume up_mispredict is raised for every update that misses and resolves taken, and for every hit whose stored direction disagrees with the effective outcome. The bench builds all of its addresses from a tag and an index with zero alignment bits. It derives up_mispredict from its own model's prediction before applying each update, so the stimulus always keeps to these assumptions. The random phase uses a small set of tags and indices so that aliasing, saturation and same-cycle lookup/update collisions occur often.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  // one saturating step toward the resolved direction
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      default: nxt = taken ? CTR_ST  : CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 6,
  parameter int ALIGN_BITS = 2,
  parameter int TAG_W      = ADDR_W - IDX_W - ALIGN_BITS
) (
  input  logic [ADDR_W-1:0]     addr,
  output logic [IDX_W-1:0]      idx,
  output logic [TAG_W-1:0]      tag,
  output logic [ALIGN_BITS-1:0] off
);
  assign off = addr[ALIGN_BITS-1:0];
  assign idx = addr[ALIGN_BITS +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/btb_tag_array.sv
module btb_tag_array
  import btb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int TAG_W   = 24
) (
  input  logic               clk,
  input  logic               rst,
  // lookup read port
  input  logic [IDX_W-1:0]   lk_idx,
  output logic               lk_ent_valid,
  output logic [TAG_W-1:0]   lk_ent_tag,
  output ctr_t               lk_ent_ctr,
  // update read port
  input  logic [IDX_W-1:0]   up_idx,
  output logic               up_ent_valid,
  output logic [TAG_W-1:0]   up_ent_tag,
  output ctr_t               up_ent_ctr,
  // write port
  input  logic               wr_en,
  input  logic               wr_alloc,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  ctr_t               wr_ctr,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  // per-slot valid flags, the only state that needs a reset
  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[e] <= 1'b0;
      end else if (wr_en && wr_alloc && (wr_idx == IDX_W'(e))) begin
        valid_q[e] <= 1'b1;
      end
    end
  end

  // tag and counter storage without reset (distributed RAM friendly)
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  assign lk_ent_valid = valid_q[lk_idx];
  assign lk_ent_tag   = tag_q[lk_idx];
  assign lk_ent_ctr   = ctr_q[lk_idx];
  assign up_ent_valid = valid_q[up_idx];
  assign up_ent_tag   = tag_q[up_idx];
  assign up_ent_ctr   = ctr_q[up_idx];
  assign valid_vec    = valid_q;

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (valid_q == '0)); // R1

  AST_ALLOC_STRONG: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_alloc) |=> (valid_q[$past(wr_idx)] && (ctr_q[$past(wr_idx)] == CTR_ST))); // R4

endmodule

// File: rtl/btb_target_ram.sv
module btb_target_ram #(
  parameter int DEPTH  = 64,
  parameter int AW     = $clog2(DEPTH),
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read-first: a same-address read returns the old word
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl
  import btb_pkg::*;
#(
  parameter int TAG_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               up_valid,
  input  logic               up_taken,
  input  logic               up_uncond,
  input  logic               up_mispredict,
  input  logic [TAG_W-1:0]   up_tag,
  input  logic               ent_valid,
  input  logic [TAG_W-1:0]   ent_tag,
  input  ctr_t               ent_ctr,
  output logic               up_hit,
  output logic               wr_en,
  output logic               wr_alloc,
  output ctr_t               wr_ctr,
  output logic               tgt_we
);

  logic eff_taken;

  // unconditional branches always count as taken
  assign eff_taken = up_taken | up_uncond;
  assign up_hit    = ent_valid && (ent_tag == up_tag);

  always_comb begin
    wr_en    = 1'b0;
    wr_alloc = 1'b0;
    wr_ctr   = ent_ctr;
    tgt_we   = 1'b0;
    if (up_valid) begin
      if (up_hit) begin
        wr_en  = 1'b1;
        wr_ctr = ctr_step(ent_ctr, eff_taken);
        tgt_we = eff_taken;
      end else if (eff_taken) begin
        wr_en    = 1'b1;
        wr_alloc = 1'b1;
        wr_ctr   = CTR_ST;
        tgt_we   = 1'b1;
      end
    end
  end

  AST_NT_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_hit && !eff_taken) |-> (!wr_en && !tgt_we)); // R3

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_hit && (ent_ctr == CTR_ST) && eff_taken) |-> (wr_ctr == CTR_ST)); // R7

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_hit && (ent_ctr == CTR_SNT) && !eff_taken) |-> (wr_ctr == CTR_SNT)); // R7

  AST_MISS_TAKEN_MISPRED: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_hit && eff_taken) |-> up_mispredict); // R4

  AST_HIT_DIR_MISPRED: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_hit && (ctr_says_taken(ent_ctr) != eff_taken)) |-> up_mispredict); // R7

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              pr_valid,
  output logic              pr_hit,
  output logic              pr_taken,
  output logic [ADDR_W-1:0] pr_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic              up_uncond,
  input  logic              up_mispredict,
  input  logic [ADDR_W-1:0] up_target
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W - ALIGN_BITS;

  logic [IDX_W-1:0]      lk_idx, up_idx;
  logic [TAG_W-1:0]      lk_tag, up_tag;
  logic [ALIGN_BITS-1:0] lk_off, up_off;

  logic                  lk_ent_valid, up_ent_valid;
  logic [TAG_W-1:0]      lk_ent_tag, up_ent_tag;
  ctr_t                  lk_ent_ctr, up_ent_ctr;
  logic [ENTRIES-1:0]    valid_vec;

  logic                  up_hit, wr_en, wr_alloc, tgt_we;
  ctr_t                  wr_ctr;

  logic                  lk_hit;
  logic                  pr_valid_q, pr_hit_q, pr_taken_q;
  logic [ADDR_W-1:0]     ram_q;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS), .TAG_W(TAG_W))
    u_lk_split (.addr(lk_addr), .idx(lk_idx), .tag(lk_tag), .off(lk_off));

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS), .TAG_W(TAG_W))
    u_up_split (.addr(up_addr), .idx(up_idx), .tag(up_tag), .off(up_off));

  btb_tag_array #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk          (clk),
    .rst          (rst),
    .lk_idx       (lk_idx),
    .lk_ent_valid (lk_ent_valid),
    .lk_ent_tag   (lk_ent_tag),
    .lk_ent_ctr   (lk_ent_ctr),
    .up_idx       (up_idx),
    .up_ent_valid (up_ent_valid),
    .up_ent_tag   (up_ent_tag),
    .up_ent_ctr   (up_ent_ctr),
    .wr_en        (wr_en),
    .wr_alloc     (wr_alloc),
    .wr_idx       (up_idx),
    .wr_tag       (up_tag),
    .wr_ctr       (wr_ctr),
    .valid_vec    (valid_vec)
  );

  btb_update_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .up_valid      (up_valid),
    .up_taken      (up_taken),
    .up_uncond     (up_uncond),
    .up_mispredict (up_mispredict),
    .up_tag        (up_tag),
    .ent_valid     (up_ent_valid),
    .ent_tag       (up_ent_tag),
    .ent_ctr       (up_ent_ctr),
    .up_hit        (up_hit),
    .wr_en         (wr_en),
    .wr_alloc      (wr_alloc),
    .wr_ctr        (wr_ctr),
    .tgt_we        (tgt_we)
  );

  btb_target_ram #(.DEPTH(ENTRIES), .AW(IDX_W), .DATA_W(ADDR_W)) u_targets (
    .clk   (clk),
    .we    (tgt_we),
    .waddr (up_idx),
    .wdata (up_target),
    .re    (lk_valid),
    .raddr (lk_idx),
    .rdata (ram_q)
  );

  assign lk_hit = lk_ent_valid && (lk_ent_tag == lk_tag);

  // result register stage, sampled before this edge's update lands
  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid_q <= 1'b0;
      pr_hit_q   <= 1'b0;
      pr_taken_q <= 1'b0;
    end else begin
      pr_valid_q <= lk_valid;
      pr_hit_q   <= lk_valid && lk_hit;
      pr_taken_q <= lk_valid && lk_hit && ctr_says_taken(lk_ent_ctr);
    end
  end

  assign pr_valid  = pr_valid_q;
  assign pr_hit    = pr_hit_q;
  assign pr_taken  = pr_taken_q;
  assign pr_target = pr_hit_q ? ram_q : '0;

  AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (pr_valid && !pr_hit) |-> !pr_taken); // R2

  AST_NT_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_hit && !up_taken && !up_uncond) |=> (valid_vec == $past(valid_vec))); // R3

  AST_RESULT_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pr_valid); // R11

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!pr_valid && !pr_hit && !pr_taken)); // R11

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ((lk_valid -> (lk_off == '0)) && (up_valid -> (up_off == '0)))); // R9

endmodule

// File: tb/btb_predictor_bench.sv
`timescale 1ns/1ps
module btb_predictor_bench;

  localparam int ADDR_W     = 32;
  localparam int ENTRIES    = 64;
  localparam int ALIGN_BITS = 2;
  localparam int IDX_W      = $clog2(ENTRIES);
  localparam int TAG_W      = ADDR_W - IDX_W - ALIGN_BITS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic              pr_valid, pr_hit, pr_taken;
  logic [ADDR_W-1:0] pr_target;
  logic              up_valid = 1'b0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic              up_taken = 1'b0;
  logic              up_uncond = 1'b0;
  logic              up_mispredict = 1'b0;
  logic [ADDR_W-1:0] up_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit                mv  [ENTRIES];
  logic [TAG_W-1:0]  mt  [ENTRIES];
  int                mc  [ENTRIES];
  logic [ADDR_W-1:0] mtg [ENTRIES];

  always #2.5 clk = ~clk;

  btb_predictor #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .ALIGN_BITS(ALIGN_BITS)) u_btb_predictor (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken), .pr_target(pr_target),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken), .up_uncond(up_uncond),
    .up_mispredict(up_mispredict), .up_target(up_target)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return {TAG_W'(tag), IDX_W'(idx), {ALIGN_BITS{1'b0}}};
  endfunction

  task automatic chk(input string req, input string what, input logic [ADDR_W-1:0] act,
                     input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit le, input logic [ADDR_W-1:0] la,
                      input bit ue, input logic [ADDR_W-1:0] ua,
                      input bit ut, input bit uu, input logic [ADDR_W-1:0] utg,
                      input string req);
    int li, ui;
    logic [TAG_W-1:0] lt, uta;
    bit ev, eh, et, uhit, eff, misp;
    logic [ADDR_W-1:0] etg;
    @(negedge clk);
    li = int'(la[ALIGN_BITS +: IDX_W]);
    lt = la[ADDR_W-1 -: TAG_W];
    ev = le;
    eh = le && mv[li] && (mt[li] == lt);
    et = eh && (mc[li] >= 2);
    etg = eh ? mtg[li] : '0;
    ui = int'(ua[ALIGN_BITS +: IDX_W]);
    uta = ua[ADDR_W-1 -: TAG_W];
    uhit = mv[ui] && (mt[ui] == uta);
    eff = ut || uu;
    misp = uhit ? (((mc[ui] >= 2) != eff) || (eff && (mtg[ui] != utg))) : eff;
    if (ue) begin
      if (uhit) begin
        mc[ui] = eff ? ((mc[ui] == 3) ? 3 : mc[ui] + 1) : ((mc[ui] == 0) ? 0 : mc[ui] - 1);
        if (eff) mtg[ui] = utg;
      end else if (eff) begin
        mv[ui] = 1'b1; mt[ui] = uta; mc[ui] = 3; mtg[ui] = utg;
      end
    end
    lk_valid = le; lk_addr = la;
    up_valid = ue; up_addr = ua; up_taken = ut; up_uncond = uu;
    up_mispredict = ue && misp; up_target = utg;
    @(posedge clk);
    #1;
    chk(req, "pr_valid",  ADDR_W'(pr_valid), ADDR_W'(ev));
    chk(req, "pr_hit",    ADDR_W'(pr_hit),   ADDR_W'(eh));
    chk(req, "pr_taken",  ADDR_W'(pr_taken), ADDR_W'(et));
    chk(req, "pr_target", pr_target, etg);
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input string req);
    step(1'b1, a, 1'b0, '0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic upd(input logic [ADDR_W-1:0] a, input bit t, input bit u,
                     input logic [ADDR_W-1:0] tg, input string req);
    step(1'b0, '0, 1'b1, a, t, u, tg, req);
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mv[i] = 1'b0; mt[i] = '0; mc[i] = 0; mtg[i] = '0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: outputs are idle straight out of reset
    chk("R1", "pr_valid after reset", ADDR_W'(pr_valid), '0);
    chk("R1", "pr_hit after reset",   ADDR_W'(pr_hit),   '0);
    // R1, R2: empty buffer misses everywhere
    for (int i = 0; i < 8; i++) look(mk(i * 7 + 1, i * 5), "R1");
    look(mk(9, 3), "R2");
    // R3: not-taken conditional miss allocates nothing
    upd(mk(5, 10), 1'b0, 1'b0, 32'h0000_1000, "R3");
    look(mk(5, 10), "R3");
    // R4: taken miss allocates strongly taken
    upd(mk(5, 10), 1'b1, 1'b0, 32'h0000_2000, "R4");
    look(mk(5, 10), "R4");
    // R7: walk the counter down, saturate, back up, saturate
    upd(mk(5, 10), 1'b0, 1'b0, 32'h0000_3000, "R7");
    look(mk(5, 10), "R7");
    upd(mk(5, 10), 1'b0, 1'b0, 32'h0000_3000, "R7");
    look(mk(5, 10), "R7");
    upd(mk(5, 10), 1'b0, 1'b0, 32'h0000_3000, "R7");
    upd(mk(5, 10), 1'b0, 1'b0, 32'h0000_3000, "R7");
    look(mk(5, 10), "R7");
    upd(mk(5, 10), 1'b1, 1'b0, 32'h0000_4000, "R8");
    look(mk(5, 10), "R6");
    upd(mk(5, 10), 1'b1, 1'b0, 32'h0000_5000, "R8");
    look(mk(5, 10), "R8");
    upd(mk(5, 10), 1'b1, 1'b0, 32'h0000_5000, "R7");
    upd(mk(5, 10), 1'b1, 1'b0, 32'h0000_5000, "R7");
    upd(mk(5, 10), 1'b0, 1'b0, 32'h0000_6000, "R8");
    look(mk(5, 10), "R8");
    // R5: unconditional with up_taken low still allocates
    upd(mk(11, 20), 1'b0, 1'b1, 32'h0000_7000, "R5");
    look(mk(11, 20), "R5");
    // R9: alias in the same slot evicts the older branch
    upd(mk(6, 10), 1'b1, 1'b0, 32'h0000_8000, "R9");
    look(mk(5, 10), "R9");
    look(mk(6, 10), "R9");
    // R10: same-cycle lookup and update see old contents
    step(1'b1, mk(3, 33), 1'b1, mk(3, 33), 1'b1, 1'b0, 32'h0000_9000, "R10");
    look(mk(3, 33), "R10");
    step(1'b1, mk(3, 33), 1'b1, mk(3, 33), 1'b0, 1'b0, 32'h0, "R10");
    step(1'b1, mk(3, 33), 1'b1, mk(3, 33), 1'b0, 1'b0, 32'h0, "R10");
    look(mk(3, 33), "R10");
    // R11: idle cycles carry no result
    step(1'b0, mk(3, 33), 1'b0, '0, 1'b0, 1'b0, '0, "R11");
    step(1'b0, mk(6, 10), 1'b0, '0, 1'b0, 1'b0, '0, "R11");
    // R6: random mix over a few tags and slots
    for (int n = 0; n < 4000; n++) begin
      step(1'($urandom_range(0, 1)), mk(int'($urandom_range(1, 3)), int'($urandom_range(0, 3))),
           1'($urandom_range(0, 1)), mk(int'($urandom_range(1, 3)), int'($urandom_range(0, 3))),
           1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
           {16'h0, 14'($urandom), 2'b00}, "R6");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule